// File: doc/BRIEF.md
# Flash Chip-Select Window Decoder

This block owns the address map of a serial-flash controller's memory window. It keeps one window register per chip select. Each register holds a start and an end boundary, counted in 8 MB units. Every write from software passes through a set of consistency rules before it is stored: the first chip select's start is pinned to the base of the overall window, updates that fall outside that window or that have an unusable size are dropped, and misaligned or overlapping windows are reported but still accepted.

On the access side, a bus address is matched against all windows at once. The block returns a one-hot chip select and the offset of the address within the selected window. A second, chip-select-relative port takes an offset aimed at a given chip select and folds it back into that select's window size, reporting any fold. The serial transfer to the flash device is handled elsewhere.

Top module: `segwin_decoder`

## Requirements
- R1: After reset, CS0 covers units 0x40..0x48 (64 MB at the base 0x2000_0000), and CS1..CS4 follow at 32 MB each: CS1 is 0x48..0x4C, CS2 is 0x4C..0x50, CS3 is 0x50..0x54 and CS4 is 0x54..0x58. All update flags are low.
- R2: The readback returns {end unit in [31:24], start unit in [23:16], 16'h0} for the chip select chosen by `cfg_rd_idx`. An index of NUM_CS or higher reads as zero.
- R3: A write whose {end, start} equals the stored value changes nothing and raises no flag.
- R4: A write to CS0 with a start other than the base unit has its start replaced by the base before any other rule applies, and `upd_fixed` pulses.
- R5: A write whose end is at or below the base unit, or whose start is above base plus window size (0x60 by default), is dropped. `upd_reject` pulses and the old value stays. A start equal to 0x60 is still accepted.
- R6: A write whose end is not above its start, or whose size (end minus start) is not a power of two, is dropped with `upd_reject`.
- R7: An accepted window whose start is not a multiple of its size pulses `upd_misalign`, and the window is stored anyway.
- R8: An accepted window that intersects another chip select's window pulses `upd_overlap`, and the window is stored anyway.
- R9: A bus address hits chip select i when start_i <= addr>>23 < end_i. `bus_cs_sel` is one-hot, the lowest-numbered hit wins, and `bus_offset` is the address minus (start_i<<23).
- R10: An address that hits no window drives `bus_cs_sel` = 0, `bus_offset` = 0 and `bus_unmapped` = 1.
- R11: `acc_off_eff` is `acc_off` modulo the size of the window of `acc_cs`. `acc_wrapped` is high when that changed the value. A chip-select index that is out of range gives 0 and no wrap.
- R12: Register updates show on the readback and the decode one cycle after the write. Each flag is a one-cycle pulse in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr_en | input | 1 | Window register write strobe |
| cfg_wr_idx | input | 3 | Chip select being written |
| cfg_wr_seg | input | 16 | New window: {end unit, start unit} |
| cfg_rd_idx | input | 3 | Chip select being read back |
| cfg_rd_data | output | 32 | Window register in register format |
| bus_addr | input | 32 | Bus address to decode |
| bus_cs_sel | output | 5 | One-hot selected chip select |
| bus_offset | output | 32 | Offset within the selected window |
| bus_unmapped | output | 1 | Address hits no window |
| acc_cs | input | 3 | Chip select for a relative access |
| acc_off | input | 32 | Relative offset requested |
| acc_off_eff | output | 32 | Offset folded into the window size |
| acc_wrapped | output | 1 | The fold changed the offset |
| upd_fixed | output | 1 | CS0 start was forced to the base |
| upd_reject | output | 1 | Last update dropped |
| upd_misalign | output | 1 | Accepted window is misaligned |
| upd_overlap | output | 1 | Accepted window overlaps another |

## Verification
Several properties are checked on every cycle. The CS0 start never leaves the base unit. A dropped update leaves the stored windows untouched, and a write of an identical value leaves no trace. The decode select is never more than one-hot, an unmapped address carries a zero offset, and an unwrapped relative offset passes through unchanged. Only the bench scenarios can show the rest: the actual reset map, the lowest-index priority when CS0 is widened over CS1, the exact range boundaries at the base and at base plus window size, and the values of the folded offsets.

// File: rtl/segwin_pkg.sv
package segwin_pkg;
  // Window boundaries are counted in 8 MB units.
  localparam int unsigned UNIT_LSB = 23;
  localparam int unsigned FIELD_W  = 8;

  typedef struct packed {
    logic [FIELD_W-1:0] end_u;
    logic [FIELD_W-1:0] start_u;
  } seg_t;
endpackage

// File: rtl/segwin_update_chk.sv
module segwin_update_chk
  import segwin_pkg::*;
#(
  parameter int unsigned NUM_CS = 5,
  parameter int unsigned IDX_W  = 3,
  parameter logic [7:0]  BASE_U = 8'h40,
  parameter logic [7:0]  WIN_U  = 8'h20
) (
  input  logic [IDX_W-1:0]        idx,
  input  seg_t                    wr_seg,
  input  seg_t [NUM_CS-1:0]       segs,
  output seg_t                    new_seg,
  output logic                    unchanged,
  output logic                    fixed,
  output logic                    reject,
  output logic                    misalign,
  output logic                    overlap
);
  logic [FIELD_W-1:0] size_u;
  logic               bad_range;
  logic               bad_size;

  assign unchanged = (wr_seg == segs[idx]);

  // CS0 start is pinned to the base of the overall window.
  always_comb begin
    new_seg = wr_seg;
    fixed   = 1'b0;
    if (idx == '0 && wr_seg.start_u != BASE_U) begin
      new_seg.start_u = BASE_U;
      fixed           = 1'b1;
    end
  end

  assign size_u    = new_seg.end_u - new_seg.start_u;
  assign bad_range = ({1'b0, new_seg.end_u} <= {1'b0, BASE_U}) ||
                     ({1'b0, new_seg.start_u} > ({1'b0, BASE_U} + {1'b0, WIN_U}));
  assign bad_size  = (new_seg.end_u <= new_seg.start_u) || ($countones(size_u) != 1);
  assign reject    = bad_range || bad_size;
  assign misalign  = |(new_seg.start_u & (size_u - 8'd1));

  always_comb begin
    overlap = 1'b0;
    for (int i = 0; i < NUM_CS; i++) begin
      if (i != int'(idx) &&
          new_seg.end_u > segs[i].start_u &&
          new_seg.start_u < segs[i].end_u)
        overlap = 1'b1;
    end
  end
endmodule

// File: rtl/segwin_addr_decode.sv
module segwin_addr_decode
  import segwin_pkg::*;
#(
  parameter int unsigned NUM_CS = 5,
  parameter int unsigned ADDR_W = 32
) (
  input  logic [ADDR_W-1:0]  addr,
  input  seg_t [NUM_CS-1:0]  segs,
  output logic [NUM_CS-1:0]  sel,
  output logic [ADDR_W-1:0]  offset,
  output logic               unmapped
);
  localparam int unsigned UW = ADDR_W - UNIT_LSB;

  logic [UW-1:0]     unit;
  logic [NUM_CS-1:0] hit;
  logic              found;

  assign unit = addr[ADDR_W-1:UNIT_LSB];

  for (genvar g = 0; g < NUM_CS; g++) begin : g_hit
    assign hit[g] = (unit >= UW'(segs[g].start_u)) && (unit < UW'(segs[g].end_u));
  end

  // Lowest-numbered matching chip select takes the access.
  always_comb begin
    sel    = '0;
    offset = '0;
    found  = 1'b0;
    for (int i = 0; i < NUM_CS; i++) begin
      if (!found && hit[i]) begin
        found  = 1'b1;
        sel[i] = 1'b1;
        offset = addr - (ADDR_W'(segs[i].start_u) << UNIT_LSB);
      end
    end
  end

  assign unmapped = !found;
endmodule

// File: rtl/segwin_decoder.sv
module segwin_decoder
  import segwin_pkg::*;
#(
  parameter int unsigned NUM_CS = 5,
  parameter int unsigned ADDR_W = 32,
  parameter logic [7:0]  BASE_U = 8'h40,
  parameter logic [7:0]  WIN_U  = 8'h20,
  parameter int unsigned CS0_U  = 8,
  parameter int unsigned CSN_U  = 4,
  localparam int unsigned IDX_W = (NUM_CS > 1) ? $clog2(NUM_CS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr_en,
  input  logic [IDX_W-1:0]  cfg_wr_idx,
  input  logic [15:0]       cfg_wr_seg,
  input  logic [IDX_W-1:0]  cfg_rd_idx,
  output logic [31:0]       cfg_rd_data,
  input  logic [ADDR_W-1:0] bus_addr,
  output logic [NUM_CS-1:0] bus_cs_sel,
  output logic [ADDR_W-1:0] bus_offset,
  output logic              bus_unmapped,
  input  logic [IDX_W-1:0]  acc_cs,
  input  logic [ADDR_W-1:0] acc_off,
  output logic [ADDR_W-1:0] acc_off_eff,
  output logic              acc_wrapped,
  output logic              upd_fixed,
  output logic              upd_reject,
  output logic              upd_misalign,
  output logic              upd_overlap
);
  function automatic seg_t dflt(input int i);
    int s;
    int n;
    s = (i == 0) ? int'(BASE_U) : int'(BASE_U) + int'(CS0_U) + (i - 1) * int'(CSN_U);
    n = (i == 0) ? int'(CS0_U) : int'(CSN_U);
    dflt.start_u = 8'(s);
    dflt.end_u   = 8'(s + n);
  endfunction

  seg_t [NUM_CS-1:0] seg_q;
  seg_t              seg_new;
  logic              wr_ok;
  logic [IDX_W-1:0]  wr_idx;
  logic              chk_unch, chk_fix, chk_rej, chk_mis, chk_ovl;
  logic              seg_we;
  logic              fix_d, rej_d, mis_d, ovl_d;

  assign wr_ok  = cfg_wr_idx < IDX_W'(NUM_CS);
  assign wr_idx = wr_ok ? cfg_wr_idx : '0;

  segwin_update_chk #(
    .NUM_CS(NUM_CS), .IDX_W(IDX_W), .BASE_U(BASE_U), .WIN_U(WIN_U)
  ) u_chk (
    .idx(wr_idx), .wr_seg(seg_t'(cfg_wr_seg)), .segs(seg_q),
    .new_seg(seg_new), .unchanged(chk_unch), .fixed(chk_fix),
    .reject(chk_rej), .misalign(chk_mis), .overlap(chk_ovl)
  );

  // Next-state for update strobe and flags.
  always_comb begin
    seg_we = 1'b0;
    fix_d  = 1'b0;
    rej_d  = 1'b0;
    mis_d  = 1'b0;
    ovl_d  = 1'b0;
    if (cfg_wr_en && wr_ok && !chk_unch) begin
      fix_d = chk_fix;
      if (chk_rej) begin
        rej_d = 1'b1;
      end else begin
        seg_we = 1'b1;
        mis_d  = chk_mis;
        ovl_d  = chk_ovl;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_CS; i++) seg_q[i] <= dflt(i);
      upd_fixed    <= 1'b0;
      upd_reject   <= 1'b0;
      upd_misalign <= 1'b0;
      upd_overlap  <= 1'b0;
    end else begin
      if (seg_we) seg_q[wr_idx] <= seg_new;
      upd_fixed    <= fix_d;
      upd_reject   <= rej_d;
      upd_misalign <= mis_d;
      upd_overlap  <= ovl_d;
    end
  end

  assign cfg_rd_data = (cfg_rd_idx < IDX_W'(NUM_CS)) ? {seg_q[cfg_rd_idx], 16'h0000} : 32'h0;

  segwin_addr_decode #(.NUM_CS(NUM_CS), .ADDR_W(ADDR_W)) u_dec (
    .addr(bus_addr), .segs(seg_q), .sel(bus_cs_sel),
    .offset(bus_offset), .unmapped(bus_unmapped)
  );

  // Chip-select-relative access folded into the window size (power of two).
  seg_t              acc_seg;
  logic              acc_ok;
  logic [7:0]        acc_size;
  logic [ADDR_W-1:0] acc_mask;

  assign acc_ok      = acc_cs < IDX_W'(NUM_CS);
  assign acc_seg     = acc_ok ? seg_q[acc_cs] : '0;
  assign acc_size    = acc_seg.end_u - acc_seg.start_u;
  assign acc_mask    = (ADDR_W'(acc_size) << UNIT_LSB) - ADDR_W'(1);
  assign acc_off_eff = acc_ok ? (acc_off & acc_mask) : '0;
  assign acc_wrapped = acc_ok && |(acc_off & ~acc_mask);

  // Checks beside the logic they guard.
  assert_cs0_start_locked_R4: assert property (@(posedge clk) disable iff (!rst_n)
    seg_q[0].start_u == BASE_U);

  assert_reject_keeps_value_R5: assert property (@(posedge clk) disable iff (!rst_n)
    upd_reject |-> $stable(seg_q));

  assert_same_write_noop_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr_en && wr_ok && cfg_wr_seg == seg_q[wr_idx]) |=>
      (!upd_fixed && !upd_reject && !upd_misalign && !upd_overlap && $stable(seg_q)));

  assert_reject_no_warn_R7: assert property (@(posedge clk) disable iff (!rst_n)
    upd_reject |-> (!upd_misalign && !upd_overlap));

  assert_sel_onehot_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(bus_cs_sel));

  assert_unmapped_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    bus_unmapped |-> (bus_cs_sel == '0 && bus_offset == '0));

  assert_nowrap_passthru_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_ok && !acc_wrapped) |-> acc_off_eff == acc_off);
endmodule

// File: tb/segwin_decoder_bench.sv
`timescale 1ns/1ps
module segwin_decoder_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_wr_en;
  logic [2:0]  cfg_wr_idx;
  logic [15:0] cfg_wr_seg;
  logic [2:0]  cfg_rd_idx;
  logic [31:0] cfg_rd_data;
  logic [31:0] bus_addr;
  logic [4:0]  bus_cs_sel;
  logic [31:0] bus_offset;
  logic        bus_unmapped;
  logic [2:0]  acc_cs;
  logic [31:0] acc_off;
  logic [31:0] acc_off_eff;
  logic        acc_wrapped;
  logic        upd_fixed, upd_reject, upd_misalign, upd_overlap;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  segwin_decoder u_segwin_decoder (
    .clk(clk), .rst_n(rst_n), .cfg_wr_en(cfg_wr_en), .cfg_wr_idx(cfg_wr_idx),
    .cfg_wr_seg(cfg_wr_seg), .cfg_rd_idx(cfg_rd_idx), .cfg_rd_data(cfg_rd_data),
    .bus_addr(bus_addr), .bus_cs_sel(bus_cs_sel), .bus_offset(bus_offset),
    .bus_unmapped(bus_unmapped), .acc_cs(acc_cs), .acc_off(acc_off),
    .acc_off_eff(acc_off_eff), .acc_wrapped(acc_wrapped), .upd_fixed(upd_fixed),
    .upd_reject(upd_reject), .upd_misalign(upd_misalign), .upd_overlap(upd_overlap)
  );

  // {address, expected select, expected offset, expected unmapped} on the reset map
  localparam logic [69:0] VEC [9] = '{
    {32'h2000_0000, 5'b00001, 32'h0000_0000, 1'b0},
    {32'h2123_4567, 5'b00001, 32'h0123_4567, 1'b0},
    {32'h23FF_FFFF, 5'b00001, 32'h03FF_FFFF, 1'b0},
    {32'h2400_0000, 5'b00010, 32'h0000_0000, 1'b0},
    {32'h2600_0010, 5'b00100, 32'h0000_0010, 1'b0},
    {32'h2900_0000, 5'b01000, 32'h0100_0000, 1'b0},
    {32'h2BFF_FFFC, 5'b10000, 32'h01FF_FFFC, 1'b0},
    {32'h2C00_0000, 5'b00000, 32'h0000_0000, 1'b1},
    {32'h1FFF_FFFF, 5'b00000, 32'h0000_0000, 1'b1}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [2:0] idx, input logic [31:0] exp, input string req);
    @(negedge clk);
    cfg_rd_idx = idx;
    #1;
    chk(req, cfg_rd_data, exp);
  endtask

  // Write, then sample flags {fixed, reject, misalign, overlap} in the pulse cycle.
  task automatic wr(input logic [2:0] idx, input logic [15:0] seg,
                    input logic [3:0] exp_flags, input string req);
    @(negedge clk);
    cfg_wr_en  = 1'b1;
    cfg_wr_idx = idx;
    cfg_wr_seg = seg;
    @(negedge clk);
    cfg_wr_en = 1'b0;
    chk(req, {28'h0, upd_fixed, upd_reject, upd_misalign, upd_overlap}, {28'h0, exp_flags});
  endtask

  task automatic dec(input logic [31:0] a, input logic [4:0] sel,
                     input logic [31:0] off, input logic unm, input string req);
    @(negedge clk);
    bus_addr = a;
    #1;
    chk(req, {27'h0, bus_cs_sel}, {27'h0, sel});
    chk(req, bus_offset, off);
    chk(req, {31'h0, bus_unmapped}, {31'h0, unm});
  endtask

  task automatic acc(input logic [2:0] cs, input logic [31:0] off,
                     input logic [31:0] exp_off, input logic exp_wrap, input string req);
    @(negedge clk);
    acc_cs  = cs;
    acc_off = off;
    #1;
    chk(req, acc_off_eff, exp_off);
    chk(req, {31'h0, acc_wrapped}, {31'h0, exp_wrap});
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; cfg_wr_en = 1'b0; cfg_wr_idx = '0; cfg_wr_seg = '0;
    cfg_rd_idx = '0; bus_addr = '0; acc_cs = '0; acc_off = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 / R2: reset map and readback format
    rd(3'd0, 32'h4840_0000, "R1 cs0 reset");
    rd(3'd1, 32'h4C48_0000, "R1 cs1 reset");
    rd(3'd2, 32'h504C_0000, "R1 cs2 reset");
    rd(3'd3, 32'h5450_0000, "R1 cs3 reset");
    rd(3'd4, 32'h5854_0000, "R1 cs4 reset");
    chk("R1 flags at reset", {28'h0, upd_fixed, upd_reject, upd_misalign, upd_overlap}, 32'h0);
    rd(3'd5, 32'h0, "R2 out-of-range read");
    rd(3'd7, 32'h0, "R2 out-of-range read");

    // R9 / R10: vector table on the reset map
    for (int i = 0; i < 9; i++)
      dec(VEC[i][69:38], VEC[i][37:33], VEC[i][32:1], VEC[i][0], "R9 R10 vector");

    // R11: fold on CS0 (64 MB)
    acc(3'd0, 32'h0400_0001, 32'h0000_0001, 1'b1, "R11 cs0 wrap");
    acc(3'd0, 32'h03FF_FFFF, 32'h03FF_FFFF, 1'b0, "R11 cs0 no wrap");
    acc(3'd6, 32'h0000_1234, 32'h0, 1'b0, "R11 bad cs");

    // R4 / R8 / R12: CS0 start forced, widened over CS1, priority goes to CS0
    wr(3'd0, 16'h5044, 4'b1001, "R4 R8 cs0 widen");
    rd(3'd0, 32'h5040_0000, "R4 R12 cs0 stored");
    dec(32'h2400_0000, 5'b00001, 32'h0400_0000, 1'b0, "R9 priority lowest cs");
    wr(3'd0, 16'h4840, 4'b0000, "R12 cs0 restore");
    chk("R12 flag pulse ends", {31'h0, upd_overlap}, 32'h0);
    dec(32'h2400_0000, 5'b00010, 32'h0, 1'b0, "R9 restored map");

    // R5: range rejects
    wr(3'd2, 16'h403C, 4'b0100, "R5 end at base");
    rd(3'd2, 32'h504C_0000, "R5 cs2 kept");
    wr(3'd3, 16'h6261, 4'b0100, "R5 start beyond window");
    rd(3'd3, 32'h5450_0000, "R5 cs3 kept");

    // R6: size rejects
    wr(3'd4, 16'h5B58, 4'b0100, "R6 size three");
    wr(3'd1, 16'h4848, 4'b0100, "R6 empty window");
    rd(3'd4, 32'h5854_0000, "R6 cs4 kept");

    // R7: misaligned but stored
    wr(3'd4, 16'h5A56, 4'b0010, "R7 misaligned accepted");
    rd(3'd4, 32'h5A56_0000, "R7 cs4 stored");
    dec(32'h2B40_0000, 5'b10000, 32'h0040_0000, 1'b0, "R9 moved cs4");
    dec(32'h2A00_0000, 5'b00000, 32'h0, 1'b1, "R10 old cs4 area");
    acc(3'd4, 32'h0210_0000, 32'h0010_0000, 1'b1, "R11 cs4 wrap");

    // R3: identical write is silent
    wr(3'd4, 16'h5A56, 4'b0000, "R3 unchanged write");
    rd(3'd4, 32'h5A56_0000, "R3 value kept");

    // R5 boundary: start equal to base plus window size is accepted
    wr(3'd4, 16'h6160, 4'b0000, "R5 start at window top");
    rd(3'd4, 32'h6160_0000, "R5 boundary stored");
    dec(32'h3000_0000, 5'b10000, 32'h0, 1'b0, "R9 boundary hit");
    dec(32'h3080_0000, 5'b00000, 32'h0, 1'b1, "R10 past boundary");

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule